// File: doc/BRIEF.md
# MDIO Management Target

This block is the target side of a clause-22 management bus. An external controller drives a clock (MDC) and shares a bidirectional data line (MDIO) with the block. The block recognises read and write frames addressed to any of a few consecutive PHY addresses, one per port. It serves eight 16-bit registers per port. A write frame updates one register. A read frame makes the block take over the line for the second turnaround bit and the 16 data bits.

MDC and MDIO are brought into a system clock that runs at least four times faster than MDC, through a synchronizer chain. Every frame bit is taken on the detected rising edge of MDC. Outputs change only a few system cycles after that edge, so they are settled long before the controller samples them on the next rising edge. A separate local read port lets the logic next to the block read any register.

Top module: `mdio_target`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones on the line, followed by the start pattern 0 then 1. If the run of ones is shorter, the frame has no effect: no register changes and the line is not driven.
- R2: The opcode is the two bits after the start pattern. Bits 1 then 0 mean read, and bits 0 then 1 mean write. Opcodes 00 and 11, and a start pattern other than 01, abort the frame with no effect.
- R3: The block answers PHY addresses BASE_PHY up to BASE_PHY+PORTS-1. Port index = PHY address minus BASE_PHY. For any other PHY address, mdio_oe stays low for the whole frame and no register is written.
- R4: On a matching read, the line stays released during the first turnaround bit. The block drives 0 during the second turnaround bit, then the 16 data bits, MSB first. It releases the line after the last data bit.
- R5: A matching write stores its 16 data bits, sent MSB first, into the addressed register once the last data bit has arrived.
- R6: Each port has eight independent registers, at register addresses 0h to 5h, 1Dh and 1Fh. A read of any other register address returns zero, and a write to any other register address changes nothing.
- R7: mdio_o and mdio_oe change only right after a detected MDC rising edge. They hold steady for the rest of each MDC period.
- R8: After reset, every register reads as zero and mdio_oe is low.
- R9: The local port returns, one system clock later, the register at (lcl_port, lcl_slot). Slots 0 to 5 are register addresses 0h to 5h, slot 6 is 1Dh and slot 7 is 1Fh.
- R10: A zero seen before 32 ones have been counted, or an aborted frame, restarts the count. The next frame needs a fresh run of 32 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the controller |
| mdio_i | input | 1 | Resolved level of the shared data line |
| mdio_o | output | 1 | Value the block drives onto the line |
| mdio_oe | output | 1 | High while the block drives the line |
| lcl_port | input | PORT_W | Port index for the local read port |
| lcl_slot | input | 3 | Register slot for the local read port |
| lcl_rdata | output | DW | Local read data, registered |

## Verification
The bench builds the block with PORTS=3 and BASE_PHY=6. With three ports in a two-bit index, one port code is never used. The non-zero base exercises the offset subtraction, and rejected PHY addresses can be tested on both sides of the window and at 0 and 31. With these values, the bench can sweep all 32 register addresses on every port for both writes and reads. It then compares each read value against a model filled from the write pattern. It also covers the malformed frames: a 31-bit preamble, a zero in the middle of the preamble, bad start patterns and both illegal opcodes.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_SOF,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DAT
  } mdio_state_e;

  localparam int unsigned SLOT_W = 3;

  // {implemented, slot} for a 5-bit register address
  function automatic logic [SLOT_W:0] reg_to_slot(input logic [4:0] addr);
    if (addr <= 5'h05) return {1'b1, addr[2:0]};
    else if (addr == 5'h1D) return 4'b1110;
    else if (addr == 5'h1F) return 4'b1111;
    else return 4'b0000;
  endfunction

endpackage

// File: rtl/mdio_target_sync.sv
module mdio_target_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_stb,
  output logic bit_val
);

  logic [STAGES-1:0] mdc_q;
  logic [STAGES-1:0] dat_q;
  logic              mdc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q <= '0;
      dat_q <= '1;
      mdc_d <= 1'b0;
    end else begin
      mdc_q <= {mdc_q[STAGES-2:0], mdc_i};
      dat_q <= {dat_q[STAGES-2:0], mdio_i};
      mdc_d <= mdc_q[STAGES-1];
    end
  end

  assign bit_stb = mdc_q[STAGES-1] & ~mdc_d;
  assign bit_val = dat_q[STAGES-1];

  // R7: a detected edge lasts exactly one system cycle
  assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/mdio_target_regs.sv
module mdio_target_regs #(
  parameter int DW    = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [DW-1:0]    ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [DW-1:0]    rb_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    ra_raw, rb_raw;
  logic             ra_v, rb_v;

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    ra_raw <= mem[ra_idx];
    rb_raw <= mem[rb_idx];
  end

  // per-entry written flags give the zero reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      ra_v <= 1'b0;
      rb_v <= 1'b0;
    end else begin
      if (we) vld[widx] <= 1'b1;
      ra_v <= vld[ra_idx];
      rb_v <= vld[rb_idx];
    end
  end

  assign ra_data = ra_v ? ra_raw : '0;
  assign rb_data = rb_v ? rb_raw : '0;

endmodule

// File: rtl/mdio_target_frame.sv
module mdio_target_frame
  import mdio_target_pkg::*;
#(
  parameter int         PORTS    = 3,
  parameter logic [4:0] BASE_PHY = 5'd1,
  parameter int         DW       = 16,
  parameter int         PORT_W   = 2,
  parameter int         PRE_LEN  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bit_stb,
  input  logic                     bit_in,
  input  logic [DW-1:0]            rd_data,
  output logic [PORT_W+SLOT_W-1:0] acc_idx,
  output logic                     wr_en,
  output logic [DW-1:0]            wr_data,
  output logic                     mdio_o,
  output logic                     mdio_oe
);

  localparam int CNT_W = ($clog2(PRE_LEN + 1) > 5) ? $clog2(PRE_LEN + 1) : 5;
  localparam logic [CNT_W-1:0] PRE_MAX  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  mdio_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_rd, op_hi;
  logic [4:0]       phy_q, rga_q;
  logic [DW-1:0]    sh_q;
  logic [5:0]       phy_off;
  logic             match, hit;
  logic [SLOT_W:0]  slot_d;

  assign phy_off = {1'b0, phy_q} - {1'b0, BASE_PHY};
  assign match   = (phy_q >= BASE_PHY) && (phy_off < 6'(PORTS));
  assign slot_d  = reg_to_slot(rga_q);
  assign hit     = slot_d[SLOT_W];
  assign acc_idx = {phy_off[PORT_W-1:0], slot_d[SLOT_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_PRE;
      cnt_q   <= '0;
      is_rd   <= 1'b0;
      op_hi   <= 1'b0;
      phy_q   <= '0;
      rga_q   <= '0;
      sh_q    <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (bit_stb) begin
        case (st_q)
          ST_PRE: begin
            if (bit_in) begin
              if (cnt_q != PRE_MAX) cnt_q <= cnt_q + 1'b1;
            end else if (cnt_q == PRE_MAX) begin
              st_q  <= ST_SOF;
              cnt_q <= '0;
            end else begin
              cnt_q <= '0;
            end
          end
          ST_SOF: begin
            cnt_q <= '0;
            st_q  <= bit_in ? ST_OP : ST_PRE;
          end
          ST_OP: begin
            if (cnt_q == '0) begin
              op_hi <= bit_in;
              cnt_q <= 1;
            end else begin
              cnt_q <= '0;
              if (op_hi != bit_in) begin
                is_rd <= op_hi;
                st_q  <= ST_PHY;
              end else begin
                st_q <= ST_PRE;
              end
            end
          end
          ST_PHY: begin
            phy_q <= {phy_q[3:0], bit_in};
            if (cnt_q == 4) begin
              cnt_q <= '0;
              st_q  <= ST_REG;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_REG: begin
            rga_q <= {rga_q[3:0], bit_in};
            if (cnt_q == 4) begin
              cnt_q <= '0;
              st_q  <= ST_TA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_TA: begin
            if (cnt_q == '0) begin
              sh_q  <= (match && hit) ? rd_data : '0;
              cnt_q <= 1;
              if (is_rd && match) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              cnt_q <= '0;
              st_q  <= ST_DAT;
              if (is_rd) begin
                mdio_o <= sh_q[DW-1];
                sh_q   <= {sh_q[DW-2:0], 1'b0};
              end
            end
          end
          ST_DAT: begin
            if (is_rd) begin
              if (cnt_q == LAST_BIT) begin
                mdio_oe <= 1'b0;
                cnt_q   <= '0;
                st_q    <= ST_PRE;
              end else begin
                mdio_o <= sh_q[DW-1];
                sh_q   <= {sh_q[DW-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
              end
            end else begin
              sh_q <= {sh_q[DW-2:0], bit_in};
              if (cnt_q == LAST_BIT) begin
                wr_en   <= match && hit;
                wr_data <= {sh_q[DW-2:0], bit_in};
                cnt_q   <= '0;
                st_q    <= ST_PRE;
              end else cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            st_q  <= ST_PRE;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  // R7: line outputs move only in the cycle after a detected MDC edge
  assert_out_on_edge_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable({mdio_o, mdio_oe}) |-> $past(bit_stb));

  // R4: the first driven bit of a read is the turnaround zero
  assert_ta_zero_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R3: only a read to a matching address drives the line
  assert_drive_match_R3: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (is_rd && match));

  // R1: the preamble count saturates at its limit
  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PRE) |-> (cnt_q <= PRE_MAX));

endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
  parameter int         PORTS       = 3,
  parameter logic [4:0] BASE_PHY    = 5'd1,
  parameter int         DW          = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        PORT_W      = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic [PORT_W-1:0] lcl_port,
  input  logic [2:0]        lcl_slot,
  output logic [DW-1:0]     lcl_rdata
);

  localparam int IDX_W = PORT_W + mdio_target_pkg::SLOT_W;

  logic             bit_stb, bit_val;
  logic [IDX_W-1:0] acc_idx;
  logic             wr_en;
  logic [DW-1:0]    wr_data, rd_data;

  mdio_target_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .mdc_i  (mdc),
    .mdio_i (mdio_i),
    .bit_stb(bit_stb),
    .bit_val(bit_val)
  );

  mdio_target_frame #(
    .PORTS   (PORTS),
    .BASE_PHY(BASE_PHY),
    .DW      (DW),
    .PORT_W  (PORT_W),
    .PRE_LEN (32)
  ) u_frame (
    .clk    (clk),
    .rst    (rst),
    .bit_stb(bit_stb),
    .bit_in (bit_val),
    .rd_data(rd_data),
    .acc_idx(acc_idx),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
  );

  mdio_target_regs #(.DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .widx   (acc_idx),
    .wdata  (wr_data),
    .ra_idx (acc_idx),
    .ra_data(rd_data),
    .rb_idx ({lcl_port, lcl_slot}),
    .rb_data(lcl_rdata)
  );

endmodule

// File: tb/mdio_target_tb.sv
module mdio_target_tb;

  localparam int         PORTS = 3;
  localparam logic [4:0] BASE  = 5'd6;
  localparam int         HALF  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b0;
  logic        ctl_oe = 1'b0;
  logic        ctl_v = 1'b1;
  logic        line;
  logic        mdio_o, mdio_oe;
  logic [1:0]  lcl_port;
  logic [2:0]  lcl_slot;
  logic [15:0] lcl_rdata;

  assign line = mdio_oe ? mdio_o : (ctl_oe ? ctl_v : 1'b1);

  always #10 clk = ~clk;

  mdio_target #(.PORTS(PORTS), .BASE_PHY(BASE), .DW(16), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .lcl_port(lcl_port), .lcl_slot(lcl_slot), .lcl_rdata(lcl_rdata)
  );

  int nchk = 0;
  int nerr = 0;
  logic [15:0] model [PORTS][8];
  logic seen_b, stab_b, oe_b, oe_any;
  logic [15:0] rd_val;
  logic ta1_rel, ta2_zero, rel_after, stab_all;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int slot_of(input logic [4:0] a);
    if (a <= 5'd5) return int'(a);
    if (a == 5'h1D) return 6;
    if (a == 5'h1F) return 7;
    return -1;
  endfunction

  function automatic logic [15:0] pat(input int p, input int a);
    return 16'hA5C3 ^ 16'(p << 12) ^ 16'(a * 16'h0421);
  endfunction

  // one MDC period: low half then high half, line sampled just before the rise
  task automatic mbit(input logic drv, input logic v);
    logic e;
    @(negedge clk);
    mdc = 1'b0; ctl_oe = drv; ctl_v = v;
    @(negedge clk);
    e = line;
    if (mdio_oe) oe_any = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    seen_b = line; oe_b = mdio_oe; stab_b = (e === seen_b);
    if (mdio_oe) oe_any = 1'b1;
    mdc = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic xfer(input int npre, input int brk, input logic [1:0] sof,
                      input logic [1:0] op, input logic [4:0] phy,
                      input logic [4:0] ra, input logic [15:0] wd);
    oe_any = 1'b0; stab_all = 1'b1;
    mbit(1'b1, 1'b0);
    for (int i = 0; i < npre; i++) mbit(1'b1, (i == brk) ? 1'b0 : 1'b1);
    mbit(1'b1, sof[1]); mbit(1'b1, sof[0]);
    mbit(1'b1, op[1]);  mbit(1'b1, op[0]);
    for (int i = 4; i >= 0; i--) mbit(1'b1, phy[i]);
    for (int i = 4; i >= 0; i--) mbit(1'b1, ra[i]);
    if (op == 2'b10) begin
      mbit(1'b0, 1'b1); ta1_rel = !oe_b;
      mbit(1'b0, 1'b1); ta2_zero = oe_b && (seen_b == 1'b0);
      for (int i = 15; i >= 0; i--) begin
        mbit(1'b0, 1'b1);
        rd_val[i] = seen_b;
        stab_all = stab_all & stab_b;
      end
    end else begin
      mbit(1'b1, 1'b1); mbit(1'b1, 1'b0);
      for (int i = 15; i >= 0; i--) mbit(1'b1, wd[i]);
    end
    mbit(1'b0, 1'b1);
    rel_after = !oe_b;
    ctl_oe = 1'b0;
  endtask

  task automatic lread(input int p, input int s);
    @(negedge clk);
    lcl_port = 2'(p); lcl_slot = 3'(s);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_locals(input string req);
    for (int p = 0; p < PORTS; p++)
      for (int s = 0; s < 8; s++) begin
        lread(p, s);
        check(req, lcl_rdata, model[p][s]);
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [4:0] bad_phy [4];
    logic [4:0] few [8];
    bad_phy = '{5'd5, 5'd9, 5'd0, 5'd31};
    few = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h1D, 5'h1F};
    for (int p = 0; p < PORTS; p++)
      for (int s = 0; s < 8; s++) model[p][s] = '0;
    lcl_port = '0; lcl_slot = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R8: reset state
    check("R8 oe after reset", 16'(mdio_oe), 16'h0);
    check_locals("R8/R9 reset locals");
    for (int k = 0; k < 8; k++) begin
      xfer(32, -1, 2'b01, 2'b10, BASE, few[k], 16'h0);
      check("R8 read after reset", rd_val, 16'h0);
    end

    // R5 R6: write every register address on every port
    for (int p = 0; p < PORTS; p++)
      for (int a = 0; a < 32; a++) begin
        xfer(32, -1, 2'b01, 2'b01, BASE + 5'(p), 5'(a), pat(p, a));
        if (slot_of(5'(a)) >= 0) model[p][slot_of(5'(a))] = pat(p, a);
      end

    // R4 R5 R6 R7: read everything back
    for (int p = 0; p < PORTS; p++)
      for (int a = 0; a < 32; a++) begin
        xfer(32, -1, 2'b01, 2'b10, BASE + 5'(p), 5'(a), 16'h0);
        if (slot_of(5'(a)) >= 0)
          check("R5/R6 read data", rd_val, model[p][slot_of(5'(a))]);
        else
          check("R6 unimplemented reads zero", rd_val, 16'h0);
        check("R4 ta first bit released", 16'(ta1_rel), 16'h1);
        check("R4 ta second bit zero", 16'(ta2_zero), 16'h1);
        check("R4 released after data", 16'(rel_after), 16'h1);
        check("R7 output steady in period", 16'(stab_all), 16'h1);
      end

    // R9: local port view
    check_locals("R9 local read");

    // R3: non-matching PHY addresses
    for (int k = 0; k < 4; k++) begin
      xfer(32, -1, 2'b01, 2'b01, bad_phy[k], 5'h00, 16'hDEAD);
      xfer(32, -1, 2'b01, 2'b10, bad_phy[k], 5'h00, 16'h0);
      check("R3 foreign read not driven", 16'(oe_any), 16'h0);
    end
    check_locals("R3 foreign write ignored");

    // R1: short preamble ignored, long preamble accepted
    xfer(31, -1, 2'b01, 2'b01, BASE, 5'h01, 16'h1357);
    lread(0, 1); check("R1 short preamble", lcl_rdata, model[0][1]);
    xfer(31, -1, 2'b01, 2'b10, BASE, 5'h01, 16'h0);
    check("R1 short preamble read not driven", 16'(oe_any), 16'h0);
    xfer(40, -1, 2'b01, 2'b01, BASE, 5'h01, 16'h2468);
    model[0][1] = 16'h2468;
    lread(0, 1); check("R1 long preamble", lcl_rdata, 16'h2468);

    // R2: bad start and bad opcodes
    xfer(32, -1, 2'b00, 2'b01, BASE + 5'd1, 5'h02, 16'h0F0E);
    lread(1, 2); check("R2 start 00", lcl_rdata, model[1][2]);
    xfer(32, -1, 2'b11, 2'b01, BASE + 5'd1, 5'h02, 16'h0F0E);
    lread(1, 2); check("R2 start 11", lcl_rdata, model[1][2]);
    xfer(32, -1, 2'b01, 2'b00, BASE + 5'd1, 5'h02, 16'h0F0E);
    lread(1, 2); check("R2 opcode 00", lcl_rdata, model[1][2]);
    check("R2 opcode 00 not driven", 16'(oe_any), 16'h0);
    xfer(32, -1, 2'b01, 2'b11, BASE + 5'd1, 5'h02, 16'h0F0E);
    lread(1, 2); check("R2 opcode 11", lcl_rdata, model[1][2]);
    check("R2 opcode 11 not driven", 16'(oe_any), 16'h0);

    // R10: zero inside preamble restarts the count; recovery after abort
    xfer(41, 20, 2'b01, 2'b01, BASE + 5'd2, 5'h1D, 16'h7777);
    lread(2, 6); check("R10 broken preamble", lcl_rdata, model[2][6]);
    xfer(32, -1, 2'b01, 2'b11, BASE + 5'd2, 5'h1D, 16'h7777);
    xfer(32, -1, 2'b01, 2'b01, BASE + 5'd2, 5'h1D, 16'h8421);
    model[2][6] = 16'h8421;
    lread(2, 6); check("R10 frame after abort", lcl_rdata, 16'h8421);
    xfer(32, -1, 2'b01, 2'b10, BASE + 5'd2, 5'h1D, 16'h0);
    check("R10 read after abort", rd_val, 16'h8421);

    summary();
    $finish;
  end

endmodule